// File: doc/BRIEF.md
# Phase-Slippable Output Clock Divider

This block takes a fast sample clock and produces an output data clock at half its rate. Software can move the phase of that divided clock one input period at a time. In a system with several converters, this lets each output clock be lined up with a common capture point.

Software uses a register-write port made of a write strobe, an address and a data word. One control register, holding a single significant bit, sits on that port. When a write moves the bit from 0 to 1, the divider swallows one input cycle: its toggle state holds for one extra input cycle. Each such command shifts the output clock by one input period, and the shifts add up.

The divided clock leaves the block in two forms: a toggling level, and a one-cycle enable that marks the input cycle just before each rising edge. A modulo counter of executed slips is also brought out so the phase can be checked. The write port is a control path and has no back-pressure. A write is taken in any cycle in which its strobe is high and reset is low.

Top module: `phase_slip_clkdiv`

## Requirements
- R1: With no slip pending, `div_clk_o` inverts on every rising edge of `clk`, giving a period of two input cycles with equal high and low times.
- R2: The control bit is bit 0 of the register at address 0x71. A write with `wr_en_i` high and `wr_addr_i` equal to 0x71 loads `wr_data_i[0]` into it. All other data bits are ignored, and writes to any other address leave the bit unchanged.
- R3: A slip is requested only by a write that changes the control bit from 0 to 1. Writing 1 while the bit is already 1, or writing 0 at any time, requests no slip, so a fresh 0 is needed before the next slip.
- R4: A slip requested by a write sampled at edge E holds `div_clk_o` unchanged at edge E+1, so that level lasts two input cycles and no high or low phase is ever shorter than one input period.
- R5: Slips accumulate. After E edges since reset, with H slips executed, `div_clk_o` equals (E - H) mod 2. One slip therefore offsets the waveform by one input period from the unslipped one, and two slips offset it by two.
- R6: `slip_cnt_o` counts executed slips modulo 2^CNT_W (default CNT_W = 1). It increments at the same edge at which the hold of R4 takes place and is otherwise stable.
- R7: `div_rise_o` is high in exactly those cycles after which the next rising edge of `clk` drives `div_clk_o` from 0 to 1.
- R8: A synchronous active-high `rst` sets `div_clk_o` to 0, the control bit to 0 and `slip_cnt_o` to 0, and cancels any pending slip. A write of 1 directly after reset therefore causes a slip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (8) | Register write address |
| wr_data_i | input | DATA_W (8) | Register write data, only bit 0 used |
| div_clk_o | output | 1 | Divided output clock (toggling level) |
| div_rise_o | output | 1 | High in the cycle before a rising edge of div_clk_o |
| slip_cnt_o | output | CNT_W (1) | Executed slips modulo 2^CNT_W |

## Verification
The assertions assume that `rst` is held high across at least one rising edge before any checked cycle, so every register holds a defined value from then on. They also assume that the write port carries known values whenever reset is low. The bench asserts reset from time zero and drives the strobe, address and data at the falling edge, to fixed values, in every cycle. It then sweeps every four-step sequence built from idle cycles, writes of 0 and 1 to the control address, writes with only the upper data bits set, and writes to another address. This covers back-to-back writes and repeated writes of 1.

// File: rtl/pslip_pkg.sv
package pslip_pkg;
  localparam int unsigned PS_ADDR_W   = 8;
  localparam int unsigned PS_DATA_W   = 8;
  localparam int unsigned PS_CNT_W    = 1;
  localparam logic [7:0]  PS_CTRL_ADR = 8'h71;

  typedef struct packed {
    logic set_one;   // write lands on the control bit with value 1
    logic set_zero;  // write lands on the control bit with value 0
  } ctrl_wr_t;
endpackage

// File: rtl/pslip_ctrl_reg.sv
module pslip_ctrl_reg
  import pslip_pkg::*;
#(
  parameter int unsigned ADDR_W = PS_ADDR_W,
  parameter logic [ADDR_W-1:0] CTRL_ADR = ADDR_W'(PS_CTRL_ADR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  output logic              slip_go
);
  ctrl_wr_t wr_dec;
  logic     ctrl_q;
  logic     go_q;

  always_comb begin
    wr_dec.set_one  = wr_en && (wr_addr == CTRL_ADR) && wr_bit;
    wr_dec.set_zero = wr_en && (wr_addr == CTRL_ADR) && !wr_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      // rising transition of the stored bit arms exactly one slip
      go_q <= wr_dec.set_one && !ctrl_q;
      if (wr_dec.set_one)
        ctrl_q <= 1'b1;
      else if (wr_dec.set_zero)
        ctrl_q <= 1'b0;
    end
  end

  assign slip_go = go_q;
endmodule

// File: rtl/pslip_div2.sv
module pslip_div2 (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic div_clk,
  output logic div_rise
);
  logic tog_q;

  always_ff @(posedge clk) begin
    if (rst)
      tog_q <= 1'b0;
    else if (!hold)
      tog_q <= ~tog_q;
  end

  assign div_clk  = tog_q;
  assign div_rise = !tog_q && !hold;
endmodule

// File: rtl/pslip_counter.sv
module pslip_counter #(
  parameter int unsigned CNT_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (bump)
      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count = cnt_q;
endmodule

// File: rtl/phase_slip_clkdiv.sv
module phase_slip_clkdiv
  import pslip_pkg::*;
#(
  parameter int unsigned ADDR_W   = PS_ADDR_W,
  parameter int unsigned DATA_W   = PS_DATA_W,
  parameter int unsigned CNT_W    = PS_CNT_W,
  parameter logic [ADDR_W-1:0] CTRL_ADR = ADDR_W'(PS_CTRL_ADR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              div_clk_o,
  output logic              div_rise_o,
  output logic [CNT_W-1:0]  slip_cnt_o
);
  logic slip_go;
  logic unused_hi_bits;

  generate
    if (DATA_W > 1) begin : g_hi
      assign unused_hi_bits = ^wr_data_i[DATA_W-1:1];
    end else begin : g_nohi
      assign unused_hi_bits = 1'b0;
    end
  endgenerate

  pslip_ctrl_reg #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADR (CTRL_ADR)
  ) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_bit  (wr_data_i[0]),
    .slip_go (slip_go)
  );

  pslip_div2 u_div (
    .clk      (clk),
    .rst      (rst),
    .hold     (slip_go),
    .div_clk  (div_clk_o),
    .div_rise (div_rise_o)
  );

  pslip_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .bump  (slip_go),
    .count (slip_cnt_o)
  );
endmodule

// File: rtl/pslip_chk.sv
module pslip_chk #(
  parameter int unsigned CNT_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             slip_go,
  input logic             div_clk,
  input logic             div_rise,
  input logic [CNT_W-1:0] slip_cnt
);
  // R1
  toggle_free_chk: assert property (@(posedge clk) disable iff (rst)
    !slip_go |=> (div_clk != $past(div_clk)));

  // R4
  slip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    slip_go |=> $stable(div_clk));

  // R3
  slip_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    slip_go |-> $past(wr_en));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    slip_go |=> (slip_cnt == CNT_W'($past(slip_cnt) + 1'b1)));

  // R6
  cnt_still_chk: assert property (@(posedge clk) disable iff (rst)
    !slip_go |=> $stable(slip_cnt));

  // R7
  rise_mark_chk: assert property (@(posedge clk) disable iff (rst)
    div_rise |=> $rose(div_clk));

  // R7
  rise_only_chk: assert property (@(posedge clk) disable iff (rst)
    !div_rise |=> !$rose(div_clk));

  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!div_clk && slip_cnt == '0 && !slip_go));
endmodule

bind phase_slip_clkdiv pslip_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en_i),
  .slip_go  (slip_go),
  .div_clk  (div_clk_o),
  .div_rise (div_rise_o),
  .slip_cnt (slip_cnt_o)
);

// File: tb/tb_phase_slip_clkdiv.sv
module tb_phase_slip_clkdiv;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned CW = 1;
  localparam logic [AW-1:0] CADR = 8'h71;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic div_clk, div_rise;
  logic [CW-1:0] slip_cnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // model state, from the requirements
  int edges, holds;
  bit ctrl_m, hold_next;

  always #2 clk = ~clk;

  phase_slip_clkdiv #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .CTRL_ADR(CADR)) dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .div_clk_o(div_clk), .div_rise_o(div_rise), .slip_cnt_o(slip_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at edge %0d", req, act, exp, edges);
    end
  endtask

  task automatic check_all();
    int ed;
    ed = (edges - holds) & 1;
    chk("R1/R5 div_clk", int'(div_clk), ed);
    chk("R6 slip_cnt", int'(slip_cnt), holds % (1 << CW));
    chk("R7 div_rise", int'(div_rise), int'(!hold_next && ed == 0));
  endtask

  // one input cycle with the given write, then check at the falling edge
  task automatic tick(input bit en, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit eff;
    wr_en = en; wr_addr = a; wr_data = d;
    @(posedge clk);
    eff = en && (a == CADR) && d[0] && !ctrl_m;   // R3 rising transition
    if (en && a == CADR) ctrl_m = d[0];            // R2
    edges++;
    if (hold_next) holds++;                        // R4 hold one edge later
    hold_next = eff;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    check_all();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wr_en = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    edges = 0; holds = 0; ctrl_m = 0; hold_next = 0;
    // R8 reset state
    chk("R8 div_clk after reset", int'(div_clk), 0);
    chk("R8 slip_cnt after reset", int'(slip_cnt), 0);
    chk("R8 div_rise after reset", int'(div_rise), 1);
  endtask

  task automatic apply_op(input int op);
    case (op)
      0: tick(1'b0, CADR, 8'h01);     // idle, lines carry a stale value
      1: tick(1'b1, CADR, 8'h00);     // R2 write 0
      2: tick(1'b1, CADR, 8'h01);     // R3 write 1
      3: tick(1'b1, 8'h70, 8'hFF);    // R2 other address, ignored
      4: tick(1'b1, CADR, 8'hFE);     // R2 upper bits set, bit 0 clear
      default: tick(1'b1, 8'h72, 8'h00); // R2 other address
    endcase
  endtask

  initial begin
    do_reset();
    // R1 free run
    for (int i = 0; i < 8; i++) tick(1'b0, '0, '0);
    // R8 write of 1 right after reset slips; R3 repeat 1 does not
    do_reset();
    tick(1'b1, CADR, 8'h01);
    tick(1'b0, '0, '0);
    chk("R8 slip after reset", int'(slip_cnt), 1);
    tick(1'b1, CADR, 8'h01);
    tick(1'b0, '0, '0);
    chk("R3 repeated 1 no slip", int'(slip_cnt), 1);
    // R5 two slips restore the original phase
    tick(1'b1, CADR, 8'h00);
    tick(1'b1, CADR, 8'h01);
    tick(1'b0, '0, '0);
    chk("R5 two slips", int'(div_clk), edges & 1);
    // near-exhaustive sweep over four-step sequences
    for (int s = 0; s < 6 * 6 * 6 * 6; s++) begin
      int v;
      do_reset();
      v = s;
      for (int k = 0; k < 4; k++) begin
        apply_op(v % 6);
        v = v / 6;
      end
      for (int k = 0; k < 3; k++) tick(1'b0, '0, '0);
    end
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule